// File: doc/BRIEF.md
# Pulse-Width Single-Wire Level Decoder

This block takes a 5-bit brightness code from a single wire that rests high and is pulled low by an open-drain driver. A sender encodes each symbol in the length of one low pulse. A short pulse is a one. A pulse about three times longer is a zero. A pulse far longer than either commits the code. The block synchronises the wire to the system clock and measures each low stretch in whole microseconds, using a tick derived from the clock. It sorts every pulse into one, zero, commit or reject.

Decoded bits enter a shift register with the first-sent bit ending up most significant. A commit copies the five newest bits into a held level register and raises a one-cycle update strobe. Short high blips inside a pulse count as noise and do not end it. Dropping the enable input, or raising the brown-out input, clears every register. After either event the level restarts at zero and the code must be sent again.

Top module: `pwl_decoder`

## Requirements
- R1: While `rst_n` is low, `en` is low or `brownout` is high, `level` reads 0 and `level_upd` is low. Bits received before such a clear are forgotten, so a commit pulse sent straight after it yields level 0.
- R2: `sdin` passes through two flip-flops before it is measured. A level held for K clocks on the synchronised line counts floor(K / CLK_PER_US) microsecond ticks. The tick count restarts at every change of that line.
- R3: A low pulse measuring 15 to 45 ticks inclusive shifts a 1 into the bit register.
- R4: A low pulse measuring 90 to 120 ticks inclusive shifts a 0 into the bit register.
- R5: Bits arrive most significant first. The sequence 1,0,1,0,0 followed by a commit gives level 20 (binary 10100), and only the five most recent bits are kept.
- R6: When a low pulse reaches 215 ticks, `level` takes the five held bits and `level_upd` is high for one cycle. Both change in the cycle after the 215th tick, while the line is still low.
- R7: A commit pulse that stays low beyond 215 ticks, however long, raises `level_upd` only once.
- R8: Low pulses of fewer than 15 ticks, 46 to 89 ticks, or 121 to 214 ticks change neither the bit register nor `level`.
- R9: A high stretch of fewer than 3 ticks between two low stretches does not end the pulse. The low ticks on both sides add up, and the pulse is classified only once the line has stayed high for 3 ticks.
- R10: `level` changes only in a cycle where `level_upd` is high, or as a result of a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low clears all state synchronously |
| brownout | input | 1 | Supply-low indication; high clears all state synchronously |
| sdin | input | 1 | Asynchronous single-wire data line, idles high |
| level | output | LEVEL_W | Held brightness code, 0 to 31 |
| level_upd | output | 1 | One-cycle strobe when a commit loads `level` |

## Verification
Most internal errors do not show at the ports right away. A bit shifted wrongly, a tick miscounted, or a glitch that wrongly ends a pulse stays hidden in the bit register until the next commit. That commit can come a full code frame later, several hundred microseconds after the fault. For this reason every frame ends in a commit whose value is known. The pulse widths are placed on both sides of each window edge, so a counter that is off by one tick gives a wrong level at that commit. Faults in the strobe or in the hold path appear within one cycle. The bench compares `level` and `level_upd` against a behavioural model on every clock, so such faults are caught in the cycle they happen.

// File: rtl/pwl_pkg.sv
package pwl_pkg;

    // Phase of the pulse-width measurement
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // line high, no pulse pending
        PH_LOW  = 2'd1,   // line low, accumulating low ticks
        PH_GAP  = 2'd2    // line high after a low, not yet long enough to close the pulse
    } phase_e;

endpackage

// File: rtl/pwl_sync.sv
module pwl_sync #(
    parameter int  STAGES   = 2,
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic din_i,
    output logic lvl_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din_i};
        if (clr_i) begin
            chain_d = {STAGES{IDLE_VAL}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{IDLE_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign lvl_o = chain_q[STAGES-1];

endmodule

// File: rtl/pwl_tick.sv
module pwl_tick #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic lvl_i,
    output logic tick_o
);

    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic          prev;
        logic [PW-1:0] pre;
    } tick_s;

    tick_s         s_d, s_q;
    logic [PW-1:0] base;

    // The cycle in which the line changes counts as the first clock of the new level
    always_comb begin
        s_d      = s_q;
        base     = (lvl_i != s_q.prev) ? '0 : s_q.pre;
        tick_o   = (base == PW'(DIV - 1));
        s_d.prev = lvl_i;
        s_d.pre  = tick_o ? '0 : base + PW'(1);
        if (clr_i) begin
            s_d.prev = 1'b1;
            s_d.pre  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{prev: 1'b1, pre: '0};
        end else begin
            s_q <= s_d;
        end
    end

    // Ticks are never back to back when the divider exceeds one
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && (DIV > 1)) |=> !tick_o);

endmodule

// File: rtl/pwl_width.sv
module pwl_width
    import pwl_pkg::*;
#(
    parameter int ONE_MIN  = 15,
    parameter int ONE_MAX  = 45,
    parameter int ZERO_MIN = 90,
    parameter int ZERO_MAX = 120,
    parameter int LOAD_AT  = 215,
    parameter int GAP_MIN  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic lvl_i,
    input  logic tick_i,
    output logic bit_vld_o,
    output logic bit_val_o,
    output logic load_o
);

    localparam int LW = $clog2(LOAD_AT + 1);
    localparam int HW = $clog2(GAP_MIN + 1);

    typedef struct packed {
        phase_e        phase;
        logic [LW-1:0] lowcnt;
        logic [HW-1:0] hicnt;
    } width_s;

    width_s        s_d, s_q;
    logic [LW-1:0] lbase, lnext;
    logic [HW-1:0] hbase, hnext;
    logic          is_one, is_zero;

    assign is_one  = (s_q.lowcnt >= LW'(ONE_MIN))  && (s_q.lowcnt <= LW'(ONE_MAX));
    assign is_zero = (s_q.lowcnt >= LW'(ZERO_MIN)) && (s_q.lowcnt <= LW'(ZERO_MAX));

    always_comb begin
        s_d       = s_q;
        bit_vld_o = 1'b0;
        bit_val_o = 1'b0;
        load_o    = 1'b0;
        lbase     = (s_q.phase == PH_IDLE) ? '0 : s_q.lowcnt;
        lnext     = lbase;
        hbase     = (s_q.phase == PH_LOW) ? '0 : s_q.hicnt;
        hnext     = hbase;

        if (!lvl_i) begin
            // Low: start or continue the pulse; a short high gap merges in
            if (tick_i && (lbase < LW'(LOAD_AT))) begin
                lnext  = lbase + LW'(1);
                load_o = (lnext == LW'(LOAD_AT));
            end
            s_d.phase  = PH_LOW;
            s_d.lowcnt = lnext;
            s_d.hicnt  = '0;
        end else if (s_q.phase != PH_IDLE) begin
            // High after a low: close the pulse once the gap is long enough
            if (tick_i) begin
                hnext = hbase + HW'(1);
            end
            if (hnext >= HW'(GAP_MIN)) begin
                bit_vld_o  = is_one || is_zero;
                bit_val_o  = is_one;
                s_d.phase  = PH_IDLE;
                s_d.lowcnt = '0;
                s_d.hicnt  = '0;
            end else begin
                s_d.phase = PH_GAP;
                s_d.hicnt = hnext;
            end
        end

        if (clr_i) begin
            s_d       = '{phase: PH_IDLE, lowcnt: '0, hicnt: '0};
            bit_vld_o = 1'b0;
            bit_val_o = 1'b0;
            load_o    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, lowcnt: '0, hicnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    // Low-time counter saturates at the commit threshold
    assert_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.lowcnt <= LW'(LOAD_AT));

    // Commit request lasts a single cycle per pulse
    assert_load_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);

    // A low after a short gap resumes the same pulse without losing ticks
    assert_merge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_GAP && !lvl_i && !clr_i) |=>
            (s_q.phase == PH_LOW && s_q.lowcnt >= $past(s_q.lowcnt)));

    // Bits are only released while the line is high after a pulse
    assert_bit_at_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld_o |-> (lvl_i && s_q.phase != PH_IDLE));

endmodule

// File: rtl/pwl_level.sv
module pwl_level #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         bit_vld_i,
    input  logic         bit_val_i,
    input  logic         load_i,
    output logic [W-1:0] level_o,
    output logic         upd_o
);

    typedef struct packed {
        logic [W-1:0] sh;
        logic [W-1:0] level;
        logic         upd;
    } level_s;

    level_s s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.upd = 1'b0;
        if (bit_vld_i) begin
            s_d.sh = {s_q.sh[W-2:0], bit_val_i};
        end
        if (load_i) begin
            s_d.level = s_q.sh;
            s_d.upd   = 1'b1;
        end
        if (clr_i) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign level_o = s_q.level;
    assign upd_o   = s_q.upd;

    assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (s_q.level == '0 && !s_q.upd));

    assert_upd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.upd |=> !s_q.upd);

    assert_level_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.level) |-> (s_q.upd || $past(clr_i)));

    // A commit never coincides with a bit arriving
    assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && bit_vld_i));

endmodule

// File: rtl/pwl_decoder.sv
module pwl_decoder #(
    parameter int CLK_PER_US  = 100,
    parameter int SYNC_STAGES = 2,
    parameter int LEVEL_W     = 5,
    parameter int ONE_MIN_US  = 15,
    parameter int ONE_MAX_US  = 45,
    parameter int ZERO_MIN_US = 90,
    parameter int ZERO_MAX_US = 120,
    parameter int LOAD_US     = 215,
    parameter int GAP_MIN_US  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               brownout,
    input  logic               sdin,
    output logic [LEVEL_W-1:0] level,
    output logic               level_upd
);

    logic clr;
    logic lvl;
    logic tick;
    logic bit_vld, bit_val, load;

    assign clr = !en || brownout;

    pwl_sync #(
        .STAGES   (SYNC_STAGES),
        .IDLE_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .din_i (sdin),
        .lvl_o (lvl)
    );

    pwl_tick #(
        .DIV (CLK_PER_US)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .lvl_i  (lvl),
        .tick_o (tick)
    );

    pwl_width #(
        .ONE_MIN  (ONE_MIN_US),
        .ONE_MAX  (ONE_MAX_US),
        .ZERO_MIN (ZERO_MIN_US),
        .ZERO_MAX (ZERO_MAX_US),
        .LOAD_AT  (LOAD_US),
        .GAP_MIN  (GAP_MIN_US)
    ) u_width (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr),
        .lvl_i     (lvl),
        .tick_i    (tick),
        .bit_vld_o (bit_vld),
        .bit_val_o (bit_val),
        .load_o    (load)
    );

    pwl_level #(
        .W (LEVEL_W)
    ) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr),
        .bit_vld_i (bit_vld),
        .bit_val_i (bit_val),
        .load_i    (load),
        .level_o   (level),
        .upd_o     (level_upd)
    );

endmodule

// File: tb/pwl_decoder_tb.sv
module pwl_decoder_tb;

    localparam int DIV   = 2;
    localparam int LOADU = 215;
    localparam int GAPU  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic       brownout = 1'b0;
    logic       sdin = 1'b1;
    logic [4:0] level;
    logic       level_upd;

    always #5 clk = ~clk;

    pwl_decoder #(.CLK_PER_US(DIV)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .brownout  (brownout),
        .sdin      (sdin),
        .level     (level),
        .level_upd (level_upd)
    );

    int    vectors = 0;
    int    fails   = 0;
    int    strobes = 0;
    int    cycles  = 0;
    string cur_req = "R1";

    // Behavioural reference: integers only
    int m_s1, m_s2, m_prev, m_run, m_mode, m_low, m_hi, m_sh, m_level, m_upd;

    task automatic model_clear();
        m_s1 = 1; m_s2 = 1; m_prev = 1; m_run = 0; m_mode = 0;
        m_low = 0; m_hi = 0; m_sh = 0; m_level = 0; m_upd = 0;
    endtask

    initial model_clear();

    always @(posedge clk) begin
        if (!rst_n || !en || brownout) begin
            model_clear();
        end else begin
            int lvl;
            bit tick;
            lvl  = m_s2;
            m_s2 = m_s1;
            m_s1 = int'(sdin);
            m_run = (lvl != m_prev) ? 1 : m_run + 1;
            m_prev = lvl;
            tick  = (m_run % DIV) == 0;
            m_upd = 0;
            if (lvl == 0) begin
                if (m_mode == 0) m_low = 0;
                m_mode = 1;
                if (tick && m_low < LOADU) begin
                    m_low++;
                    if (m_low == LOADU) begin
                        m_level = m_sh;
                        m_upd   = 1;
                    end
                end
            end else if (m_mode != 0) begin
                if (m_mode == 1) m_hi = 0;
                m_mode = 2;
                if (tick) m_hi++;
                if (m_hi >= GAPU) begin
                    if (m_low >= 15 && m_low <= 45)       m_sh = ((m_sh << 1) | 1) & 31;
                    else if (m_low >= 90 && m_low <= 120) m_sh = (m_sh << 1) & 31;
                    m_mode = 0;
                    m_low  = 0;
                end
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            if (int'(level) != m_level || int'(level_upd) != m_upd) begin
                fails++;
                $display("FAIL %s cycle-compare: actual level=%0d upd=%0d expected level=%0d upd=%0d",
                         cur_req, level, level_upd, m_level, m_upd);
            end
            if (level_upd) strobes++;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual cycles=%0d expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s direct-check: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic low_us(int us);
        sdin = 1'b0;
        repeat (us * DIV) @(negedge clk);
        sdin = 1'b1;
    endtask

    task automatic high_us(int us);
        sdin = 1'b1;
        repeat (us * DIV) @(negedge clk);
    endtask

    task automatic send_bit(bit b);
        low_us(b ? 30 : 100);
        high_us(5);
    endtask

    task automatic send_load(int us);
        low_us(us);
        high_us(5);
    endtask

    task automatic send_code(int code);
        for (int i = 4; i >= 0; i--) send_bit(code[i]);
        send_load(220);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk("R1", int'(level), 0);
        chk("R1", int'(level_upd), 0);

        // R5: MSB-first framing
        cur_req = "R5";
        send_code(20);
        chk("R5", int'(level), 20);
        cur_req = "R3";
        send_code(31);
        chk("R3", int'(level), 31);
        cur_req = "R4";
        send_code(0);
        chk("R4", int'(level), 0);
        cur_req = "R6";
        send_code(5);
        chk("R6", int'(level), 5);

        // Window edges: 15,45 -> 1 ; 90,120 -> 0 ; others rejected (R8)
        cur_req = "R3";
        low_us(15);  high_us(5);
        low_us(45);  high_us(5);
        cur_req = "R4";
        low_us(90);  high_us(5);
        low_us(120); high_us(5);
        cur_req = "R8";
        low_us(14);  high_us(5);
        low_us(46);  high_us(5);
        low_us(89);  high_us(5);
        low_us(121); high_us(5);
        low_us(214); high_us(5);
        chk("R10", int'(level), 5);
        send_load(215);
        chk("R8", int'(level), 28);   // 00101 then 1,1,0,0 -> 11100

        // R9: glitch merge
        cur_req = "R9";
        low_us(10); high_us(1); low_us(10); high_us(5);   // 20 ticks -> 1
        low_us(50); high_us(2); low_us(50); high_us(5);   // 100 ticks -> 0
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        send_load(220);
        chk("R9", int'(level), 22);

        // R7: one strobe for a very long commit
        cur_req = "R7";
        strobes = 0;
        send_load(400);
        chk("R7", strobes, 1);
        chk("R7", int'(level), 22);

        // R1: enable low clears, pending bits are lost
        cur_req = "R1";
        send_code(31);
        en = 1'b0;
        repeat (10) @(negedge clk);
        chk("R1", int'(level), 0);
        en = 1'b1;
        repeat (10) @(negedge clk);
        send_load(220);
        chk("R1", int'(level), 0);

        // R1: brown-out clears; R10: bits alone do not move the level
        send_code(9);
        chk("R5", int'(level), 9);
        cur_req = "R10";
        send_bit(1'b1); send_bit(1'b1);
        chk("R10", int'(level), 9);
        cur_req = "R1";
        brownout = 1'b1;
        repeat (10) @(negedge clk);
        chk("R1", int'(level), 0);
        brownout = 1'b0;
        repeat (10) @(negedge clk);
        send_load(220);
        chk("R1", int'(level), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule